// File: doc/BRIEF.md
# Floating Bus Scan Address Generator

This block works out which video-memory location the display scanner is fetching during the current CPU cycle of a frame. A read from an I/O location that has no device behind it then returns the main-RAM byte at that location. The block keeps its own position in the frame with a tick counter and a line counter. It does not use a divider. `frame_start` puts the position back to the first cycle, and `cyc_step` moves it forward by one CPU cycle.

The scanner's horizontal and vertical counts come from that position. A fixed interleaved-line formula turns them into a 16-bit address. Four mode bits then choose the display page region: text, hires, page 2 and 80-column store. The address and an "unconnected read" strobe are registered together. The memory system uses them to answer such reads from main RAM. It never answers them from auxiliary RAM.

Top module: `fbus_scan_addr`

## Requirements
- R1: While `rst_n` is low at a clock edge, `scan_addr` becomes 0, `float_rd` becomes 0 and the frame position becomes cycle 0.
- R2: The position advances by one cycle on each clock with `cyc_step` high. A frame has 65 ticks per line and 262 lines, and it wraps to cycle 0 after the last line. `frame_start` high sets the position to 0 for the next clock and has priority over `cyc_step`.
- R3: The horizontal count is tick minus one, except that tick 0 also yields 0. Ticks 0 and 1 of a line therefore give the same address.
- R4: The vertical count is (line + 250) mod 256.
- R5: The base address is built from three fields. Vertical count bits 5:3 sit at address bits 9:7. Bits 3:0 of (13 + hcount[5:3] + 5*vcount[7:6]) sit at bits 6:3. hcount[2:0] sits at bits 2:0.
- R6: When text mode is on or hires is off, the base gets 0x0800 added if page 2 is on and 80-column store is off. Otherwise it gets 0x0400.
- R7: When hires is on and text is off, the base gets 0x4000 added under the same page-2 condition and 0x2000 otherwise. It also gets vcount[2:0] shifted to address bits 12:10.
- R8: `scan_addr` shows, one clock later, the position and mode bits present at the previous clock edge.
- R9: `float_rd` is high one clock after a cycle with `io_rd` high and `io_addr` in 0xC020..0xC02F inclusive. It is low otherwise.
- R10: With `cyc_step` and `frame_start` both low, the position holds, so `scan_addr` stays constant while the mode bits are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Restart the frame position at cycle 0 |
| cyc_step | input | 1 | One CPU cycle elapses |
| text_mode | input | 1 | Text display mode |
| hires_mode | input | 1 | High-resolution graphics mode |
| page2_sel | input | 1 | Second display page selected |
| store80_on | input | 1 | 80-column store enabled |
| io_rd | input | 1 | CPU read cycle |
| io_addr | input | 16 | CPU address |
| scan_addr | output | 16 | Registered main-RAM scan address |
| float_rd | output | 1 | Registered strobe: answer this read from `scan_addr` |

## Verification
A wrong tick or line counter shows at `scan_addr` on the next clock. If it fails to wrap at the end of a line, it first shows at the following line's tick 0. If it fails to wrap at the end of the frame, it shows after the frame's final cycle. Because of this, the bench sweeps complete frames in several modes and compares every cycle against an arithmetic model. A bad vertical offset or page-select term changes the address bits at once. A wrong decode range shows on `float_rd` on the clock after the read.

// File: rtl/fbus_pkg.sv
// Package: shared widths and the display mode bundle for the floating-bus
// scan address generator. Assumes a 16-bit CPU address space.
package fbus_pkg;
    localparam int ADDR_W = 16;
    localparam int VCNT_W = 8;
    localparam int HCNT_W = 6;

    typedef struct packed {
        logic text;
        logic hires;
        logic page2;
        logic store80;
    } scan_mode_t;
endpackage

// File: rtl/fbus_scan_timer.sv
// Module: tracks the scanner position as a tick-within-line and a line
// number. Replaces a divide-by-line-length with a running counter pair.
// Assumes at most one CPU cycle elapses per clock.
module fbus_scan_timer #(
    parameter int TICKS = 65,
    parameter int LINES = 262,
    localparam int TW = $clog2(TICKS),
    localparam int LW = $clog2(LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          advance,
    output logic [TW-1:0] tick,
    output logic [LW-1:0] line
);
    localparam logic [TW-1:0] TICK_LAST = TW'(TICKS - 1);
    localparam logic [LW-1:0] LINE_LAST = LW'(LINES - 1);

    // Advance the tick, carry into the line, wrap at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            tick <= '0;
            line <= '0;
        end else if (advance) begin
            if (tick == TICK_LAST) begin
                tick <= '0;
                line <= (line == LINE_LAST) ? '0 : line + 1'b1;
            end else begin
                tick <= tick + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fbus_addr_calc.sv
// Module: combinational scan address arithmetic. Derives the horizontal
// count (zero held for two ticks) and the offset vertical count, folds
// them into the interleaved base, then adds the page region for the mode.
module fbus_addr_calc
    import fbus_pkg::*;
#(
    parameter int TW = 7,
    parameter int LW = 9,
    parameter logic [VCNT_W-1:0] V_OFFSET = 8'hFA
) (
    input  logic [TW-1:0]     tick,
    input  logic [LW-1:0]     line,
    input  scan_mode_t        mode,
    output logic [ADDR_W-1:0] addr
);
    logic [HCNT_W-1:0] hcount;
    logic [VCNT_W-1:0] vcount;
    logic [3:0]        row_sum;
    logic [9:0]        base;
    logic              alt_page;
    logic              graphics;

    // Horizontal and vertical counts from the position.
    always_comb begin
        hcount = (tick == '0) ? '0 : HCNT_W'(tick - 1'b1);
        vcount = VCNT_W'(16'(line) + 16'(V_OFFSET));
    end

    // Interleaved base address and page region selection.
    always_comb begin
        row_sum  = 4'hD + {1'b0, hcount[5:3]} + {vcount[7:6], vcount[7:6]};
        base     = {vcount[5:3], row_sum, hcount[2:0]};
        alt_page = mode.page2 & ~mode.store80;
        graphics = mode.hires & ~mode.text;
        if (graphics) begin
            addr = {6'b0, base}
                 | (alt_page ? 16'h4000 : 16'h2000)
                 | {3'b0, vcount[2:0], 10'b0};
        end else begin
            addr = {6'b0, base} | (alt_page ? 16'h0800 : 16'h0400);
        end
    end
endmodule

// File: rtl/fbus_float_decode.sv
// Module: flags CPU reads of the unconnected I/O window. The flag is
// registered so that it lines up with the registered scan address.
module fbus_float_decode
    import fbus_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_LO = 16'hC020,
    parameter logic [ADDR_W-1:0] WIN_HI = 16'hC02F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    // Register the window-hit on a read.
    always_ff @(posedge clk) begin
        if (!rst_n) hit <= 1'b0;
        else        hit <= rd && (addr >= WIN_LO) && (addr <= WIN_HI);
    end
endmodule

// File: rtl/fbus_scan_addr.sv
// Module: top of the floating-bus scan address generator. Keeps the frame
// position, computes the scanner's fetch address and registers it together
// with the unconnected-read strobe. Assumes mode bits are static or change
// between CPU cycles; the output follows them one clock later.
module fbus_scan_addr
    import fbus_pkg::*;
#(
    parameter int TICKS_PER_LINE  = 65,
    parameter int LINES_PER_FRAME = 262,
    parameter logic [VCNT_W-1:0] V_OFFSET = 8'hFA,
    parameter logic [ADDR_W-1:0] FLOAT_LO = 16'hC020,
    parameter logic [ADDR_W-1:0] FLOAT_HI = 16'hC02F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              cyc_step,
    input  logic              text_mode,
    input  logic              hires_mode,
    input  logic              page2_sel,
    input  logic              store80_on,
    input  logic              io_rd,
    input  logic [ADDR_W-1:0] io_addr,
    output logic [ADDR_W-1:0] scan_addr,
    output logic              float_rd
);
    localparam int TW = $clog2(TICKS_PER_LINE);
    localparam int LW = $clog2(LINES_PER_FRAME);

    logic [TW-1:0]     tick_w;
    logic [LW-1:0]     line_w;
    logic [ADDR_W-1:0] addr_w;
    scan_mode_t        mode_w;

    assign mode_w = '{text: text_mode, hires: hires_mode,
                      page2: page2_sel, store80: store80_on};

    fbus_scan_timer #(
        .TICKS (TICKS_PER_LINE),
        .LINES (LINES_PER_FRAME)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (frame_start),
        .advance (cyc_step),
        .tick    (tick_w),
        .line    (line_w)
    );

    fbus_addr_calc #(
        .TW       (TW),
        .LW       (LW),
        .V_OFFSET (V_OFFSET)
    ) u_calc (
        .tick (tick_w),
        .line (line_w),
        .mode (mode_w),
        .addr (addr_w)
    );

    fbus_float_decode #(
        .WIN_LO (FLOAT_LO),
        .WIN_HI (FLOAT_HI)
    ) u_decode (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (io_rd),
        .addr  (io_addr),
        .hit   (float_rd)
    );

    // Register the scan address for the memory system.
    always_ff @(posedge clk) begin
        if (!rst_n) scan_addr <= '0;
        else        scan_addr <= addr_w;
    end
endmodule

// File: rtl/fbus_scan_addr_chk.sv
// Module: assertion checker for fbus_scan_addr, attached with bind.
// Watches the position counters between the timer and the address logic.
module fbus_scan_addr_chk #(
    parameter int TICKS = 65,
    parameter int LINES = 262,
    parameter int TW = 7,
    parameter int LW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_start,
    input logic          cyc_step,
    input logic          text_mode,
    input logic          hires_mode,
    input logic          io_rd,
    input logic [TW-1:0] tick,
    input logic [LW-1:0] line,
    input logic [15:0]   scan_addr,
    input logic          float_rd
);
    p_tick_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        32'(tick) < TICKS);

    p_restart_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (tick == '0) && (line == '0));

    p_line_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_step && !frame_start && 32'(tick) == TICKS - 1 && 32'(line) != LINES - 1)
        |=> (line == $past(line) + 1'b1) && (tick == '0));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_step && !frame_start) |=> $stable(tick) && $stable(line));

    p_strobe_needs_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        float_rd |-> $past(io_rd));

    p_text_region_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (text_mode || !hires_mode) |=> scan_addr[15:12] == 4'd0);

    p_hires_region_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hires_mode && !text_mode) |=> scan_addr[14:13] != 2'd0);
endmodule

bind fbus_scan_addr fbus_scan_addr_chk #(
    .TICKS (TICKS_PER_LINE),
    .LINES (LINES_PER_FRAME),
    .TW    (TW),
    .LW    (LW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .cyc_step    (cyc_step),
    .text_mode   (text_mode),
    .hires_mode  (hires_mode),
    .io_rd       (io_rd),
    .tick        (tick_w),
    .line        (line_w),
    .scan_addr   (scan_addr),
    .float_rd    (float_rd)
);

// File: tb/fbus_scan_addr_tb.sv
// Bench: sweeps whole frames in several display modes and compares every
// cycle with an arithmetic model of the scan address.
module fbus_scan_addr_tb;
    localparam int FRAME = 65 * 262;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        cyc_step = 1'b0;
    logic        text_mode = 1'b1;
    logic        hires_mode = 1'b0;
    logic        page2_sel = 1'b0;
    logic        store80_on = 1'b0;
    logic        io_rd = 1'b0;
    logic [15:0] io_addr = 16'h0000;
    logic [15:0] scan_addr;
    logic        float_rd;

    int    errors = 0;
    int    checks = 0;
    int    cycles = 0;
    int    m_cnt = 0;
    logic [15:0] exp_addr = '0;
    logic        exp_fl = 1'b0;
    string tag = "R1";

    always #4 clk = ~clk;

    fbus_scan_addr u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cyc_step(cyc_step),
        .text_mode(text_mode), .hires_mode(hires_mode), .page2_sel(page2_sel),
        .store80_on(store80_on), .io_rd(io_rd), .io_addr(io_addr),
        .scan_addr(scan_addr), .float_rd(float_rd)
    );

    // Arithmetic model of the address for frame cycle c.
    function automatic logic [15:0] model_addr(int c, logic t, logic h, logic p2, logic s80);
        int ln, tk, hc, vc, s, base, a;
        logic alt;
        ln = c / 65;
        tk = c % 65;
        hc = (tk == 0) ? 0 : tk - 1;
        vc = (ln + 250) % 256;
        s  = (13 + (hc / 8) % 8 + 5 * (vc / 64)) % 16;
        base = ((vc / 8) % 8) * 128 + s * 8 + hc % 8;
        alt = p2 && !s80;
        if (t || !h) a = base + (alt ? 2048 : 1024);
        else         a = base + (alt ? 16384 : 8192) + (vc % 8) * 1024;
        return 16'(a);
    endfunction

    // Reference position and expected registered outputs.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            m_cnt <= 0; exp_addr <= '0; exp_fl <= 1'b0;
        end else begin
            exp_addr <= model_addr(m_cnt, text_mode, hires_mode, page2_sel, store80_on);
            exp_fl   <= io_rd && io_addr >= 16'hC020 && io_addr <= 16'hC02F;
            if (frame_start)   m_cnt <= 0;
            else if (cyc_step) m_cnt <= (m_cnt + 1) % FRAME;
        end
    end

    task automatic compare();
        checks++;
        if (scan_addr !== exp_addr) begin
            errors++;
            $display("FAIL %s scan_addr actual=%h expected=%h", tag, scan_addr, exp_addr);
        end
        checks++;
        if (float_rd !== exp_fl) begin
            errors++;
            $display("FAIL %s float_rd actual=%b expected=%b", tag, float_rd, exp_fl);
        end
    endtask

    task automatic cyc(input logic fs, input logic st);
        @(negedge clk);
        compare();
        frame_start = fs;
        cyc_step = st;
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        logic [15:0] a0, a1, a2;
        // R1 reset state
        tag = "R1";
        repeat (3) cyc(1'b0, 1'b0);
        rst_n = 1'b1;

        // R5 base arithmetic: text page 1 for one full frame plus wrap (R2)
        tag = "R5";
        for (int i = 0; i < FRAME + 70; i++) cyc(1'b0, 1'b1);
        tag = "R2";
        cyc(1'b1, 1'b1);
        for (int i = 0; i < 200; i++) cyc(1'b0, 1'b1);

        // R7 hires page 2 (store off), full frame
        tag = "R7";
        hires_mode = 1'b0; text_mode = 1'b0; hires_mode = 1'b1; page2_sel = 1'b1;
        for (int i = 0; i < FRAME; i++) cyc(1'b0, 1'b1);

        // R4 vertical offset seen through hires row bits, page 1, full frame
        tag = "R4";
        page2_sel = 1'b0;
        for (int i = 0; i < FRAME; i++) cyc(1'b0, 1'b1);

        // R6 text page 2 and lores page 2 with 80-column store on
        tag = "R6";
        text_mode = 1'b1; hires_mode = 1'b0; page2_sel = 1'b1;
        for (int i = 0; i < 3000; i++) cyc(1'b0, 1'b1);
        text_mode = 1'b0; store80_on = 1'b1;
        for (int i = 0; i < 3000; i++) cyc(1'b0, 1'b1);
        hires_mode = 1'b1;
        for (int i = 0; i < 3000; i++) cyc(1'b0, 1'b1);
        store80_on = 1'b0; hires_mode = 1'b0;

        // R10 hold with no step
        tag = "R10";
        for (int i = 0; i < 60; i++) cyc(1'b0, 1'b0);

        // R8 mode bits toggled every cycle
        tag = "R8";
        for (int i = 0; i < 400; i++) begin
            cyc(1'b0, i[0]);
            text_mode = i[1]; hires_mode = i[2]; page2_sel = i[3]; store80_on = i[4];
        end
        text_mode = 1'b1; hires_mode = 1'b0; page2_sel = 1'b0; store80_on = 1'b0;

        // R3 ticks 0 and 1 share an address, tick 2 differs
        tag = "R3";
        cyc(1'b1, 1'b1);
        cyc(1'b0, 1'b1);
        @(negedge clk); a0 = scan_addr;
        @(negedge clk); a1 = scan_addr;
        @(negedge clk); a2 = scan_addr;
        checks++;
        if (a0 !== a1) begin
            errors++;
            $display("FAIL R3 tick1 addr actual=%h expected=%h", a1, a0);
        end
        checks++;
        if (a2 === a1) begin
            errors++;
            $display("FAIL R3 tick2 addr actual=%h expected!=%h", a2, a1);
        end

        // R9 unconnected read window sweep
        tag = "R9";
        for (int k = 16'hC000; k < 16'hC040; k++) begin
            io_rd = 1'b1; io_addr = 16'(k);
            cyc(1'b0, 1'b1);
        end
        io_rd = 1'b0; io_addr = 16'hC025;
        cyc(1'b0, 1'b1);
        io_rd = 1'b1; io_addr = 16'h2025;
        cyc(1'b0, 1'b1);
        io_rd = 1'b0;
        repeat (3) cyc(1'b0, 1'b1);

        finish_run();
    end
endmodule